// File: doc/BRIEF.md
# Chained Watchpoint and Counter Breakpoint Unit

This block sits behind a processor's matchpoint comparators. Each cycle it receives an 8-bit vector of matchpoint results plus a flag saying that at least one of them fired. From these it builds ten watchpoint signals. Eight come from the matchpoints, and each can be combined with the watchpoint before it. The last two come from two event counters reaching programmed match values. Asserted watchpoints that are armed for breaking set sticky status bits and raise a one-cycle breakpoint request toward the core.

Software configures the unit through a four-entry register port with a combinational read:
- a chain register with a 2-bit combine mode per watchpoint;
- a control register holding counter enables, counter routing, break arms and the read-only status;
- two counter registers, each holding a count and a match value.

A global enable input and an in-reset input suppress all evaluation.

Top module: `wp_chain_brk`

## Requirements
- R1: The chain register (address 0) holds the mode of watchpoint i in bits [2i+1:2i]. Mode 00 passes the watchpoint's own source. Mode 01 ANDs the source with watchpoint i-1. Mode 10 ORs the source with watchpoint i-1. Mode 11 makes the watchpoint false.
- R2: Watchpoints are chained in ascending order, so watchpoint i combines with the already-chained value of watchpoint i-1; a chain of OR or AND stages carries a value through several steps in one event.
- R3: Watchpoint 0 has no predecessor: modes 01 and 10 make it false, and only mode 00 gives it the value of matchpoint 0.
- R4: Control register (address 1) bits [1:0] enable counter 0 and counter 1. Bit 2+i routes watchpoint i (0..7) to counter 1 when set and to counter 0 when clear. During an evaluated event an enabled counter adds the number of asserted watchpoints routed to it. The count wraps modulo 2^16.
- R5: Watchpoint 8 is (counter 0 count after this event's update equals its match field) combined by mode with watchpoint 7. Watchpoint 9 is the same test on counter 1, combined with watchpoint 8.
- R6: When the any-match input is low, no counter, status bit or breakpoint request changes.
- R7: Control bit 10+i arms watchpoint i. An armed watchpoint that is asserted during an evaluated event sets status bit 20+i of the control register. The breakpoint request output is high in the cycle after that event and low after an idle cycle.
- R8: No evaluation takes place while the global enable is low, while the in-reset input is high, or while every arm bit and every routing bit is zero.
- R9: Status bits stay set until any write to the control register clears them; a hit in the same cycle as that write leaves its bit set.
- R10: A counter register (addresses 2 and 3) holds the count in bits [15:0] and the match value in bits [31:16]. A write replaces both fields and takes priority over an increment in the same cycle.
- R11: After reset all four registers read zero and the breakpoint request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Global enable for evaluation |
| cpu_in_reset | input | 1 | Core held in reset; suppresses evaluation |
| mp_vec | input | 8 | Matchpoint results for this cycle |
| mp_any | input | 1 | At least one matchpoint fired this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| brk_req | output | 1 | Breakpoint request, one cycle per armed hit event |

## Verification
Two pairs of operations can fall in the same cycle, and the bench provokes both by asserting a register write in the very cycle that carries a matchpoint event.

In the first pair, a write to the control register, which clears status, lands in the same cycle as an armed hit. The bench expects the status bit to read set afterward and the breakpoint request to pulse.

In the second pair, a write to a counter register lands in the same cycle as an event that would increment that counter. The bench expects the written count and match to read back untouched, and the following event to increment from the written count.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        CH_SELF = 2'b00,
        CH_AND  = 2'b01,
        CH_OR   = 2'b10,
        CH_RSVD = 2'b11
    } chain_mode_e;

    localparam logic [1:0] ADDR_CHAIN = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_CNT0  = 2'd2;
    localparam logic [1:0] ADDR_CNT1  = 2'd3;

    // One stage of the serial watchpoint chain.
    function automatic logic chain_step(chain_mode_e mode, logic src,
                                        logic prev, logic has_prev);
        logic res;
        case (mode)
            CH_SELF: res = src;
            CH_AND:  res = has_prev & src & prev;
            CH_OR:   res = has_prev & (src | prev);
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wpc_chain.sv
module wpc_chain
    import wpc_pkg::*;
#(
    parameter  int unsigned N_MP = 8,
    localparam int unsigned N_WP = N_MP + 2
) (
    input  logic [N_MP-1:0]   mp_vec,
    input  logic [2*N_WP-1:0] chain_q,
    input  logic [1:0]        cnt_hit,
    output logic [N_MP-1:0]   wp_lo,
    output logic [1:0]        wp_hi
);

    // Matchpoint-driven stages, evaluated in ascending order.
    always_comb begin
        logic prev;
        logic cur;
        prev  = 1'b0;
        wp_lo = '0;
        for (int i = 0; i < int'(N_MP); i++) begin
            cur      = chain_step(chain_mode_e'(chain_q[2*i +: 2]), mp_vec[i],
                                  prev, (i != 0));
            wp_lo[i] = cur;
            prev     = cur;
        end
    end

    // Counter-driven stages follow the last matchpoint stage.
    always_comb begin
        wp_hi[0] = chain_step(chain_mode_e'(chain_q[2*N_MP +: 2]), cnt_hit[0],
                              wp_lo[N_MP-1], 1'b1);
        wp_hi[1] = chain_step(chain_mode_e'(chain_q[2*(N_MP+1) +: 2]), cnt_hit[1],
                              wp_hi[0], 1'b1);
    end

endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
    parameter  int unsigned N_MP   = 8,
    parameter  int unsigned CNT_W  = 16,
    localparam int unsigned DATA_W = 2 * CNT_W,
    localparam int unsigned PC_W   = $clog2(N_MP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step_en,
    input  logic [N_MP-1:0]   routed,
    output logic [DATA_W-1:0] reg_q,
    output logic              hit
);

    typedef struct packed {
        logic [CNT_W-1:0] match;
        logic [CNT_W-1:0] count;
    } cnt_reg_t;

    cnt_reg_t         q;
    logic [PC_W-1:0]  pc;
    logic [CNT_W-1:0] count_after;

    always_comb begin
        pc = '0;
        for (int i = 0; i < int'(N_MP); i++) begin
            pc = pc + PC_W'(routed[i]);
        end
    end

    assign count_after = step_en ? (q.count + CNT_W'(pc)) : q.count;
    assign hit         = (count_after == q.match);
    assign reg_q       = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= cnt_reg_t'(wr_data);
        end else begin
            q.count <= count_after;
        end
    end

    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !wr_en) |=> $stable(q.count)); // R6

    AST_CNT_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (step_en && !wr_en) |=> ((q.count - $past(q.count)) <= CNT_W'(N_MP))); // R4

    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (reg_q == $past(wr_data))); // R10

endmodule

// File: rtl/wpc_regs.sv
module wpc_regs #(
    parameter  int unsigned N_MP    = 8,
    localparam int unsigned N_WP    = N_MP + 2,
    localparam int unsigned CHAIN_W = 2 * N_WP,
    localparam int unsigned CFG_W   = 2 + N_MP + N_WP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chain_we,
    input  logic               cfg_we,
    input  logic [CHAIN_W-1:0] chain_wdata,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [N_WP-1:0]    new_hits,
    output logic [CHAIN_W-1:0] chain_q,
    output logic [1:0]         cnt_en,
    output logic [N_MP-1:0]    route,
    output logic [N_WP-1:0]    brk_en,
    output logic [N_WP-1:0]    status
);

    typedef struct packed {
        logic [N_WP-1:0] brk;
        logic [N_MP-1:0] route;
        logic [1:0]      cen;
    } cfg_t;

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            cfg_q   <= '0;
            status  <= '0;
        end else begin
            if (chain_we) chain_q <= chain_wdata;
            if (cfg_we)   cfg_q   <= cfg_t'(cfg_wdata);
            status <= (cfg_we ? '0 : status) | new_hits;
        end
    end

    assign cnt_en = cfg_q.cen;
    assign route  = cfg_q.route;
    assign brk_en = cfg_q.brk;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ((status & $past(status)) == $past(status))); // R9

    AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (new_hits != '0) |=> ((status & $past(new_hits)) == $past(new_hits))); // R7

endmodule

// File: rtl/wp_chain_brk.sv
module wp_chain_brk
    import wpc_pkg::*;
#(
    parameter int unsigned N_MP   = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              cpu_in_reset,
    input  logic [N_MP-1:0]   mp_vec,
    input  logic              mp_any,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              brk_req
);

    localparam int unsigned N_WP    = N_MP + 2;
    localparam int unsigned CNT_W   = DATA_W / 2;
    localparam int unsigned CHAIN_W = 2 * N_WP;
    localparam int unsigned CFG_W   = 2 + N_MP + N_WP;

    logic [CHAIN_W-1:0] chain_q;
    logic [1:0]         cnt_en;
    logic [N_MP-1:0]    route;
    logic [N_WP-1:0]    brk_en;
    logic [N_WP-1:0]    status;
    logic [N_WP-1:0]    new_hits;
    logic [N_MP-1:0]    wp_lo;
    logic [1:0]         wp_hi;
    logic [1:0]         cnt_hit;
    logic [1:0]         cnt_we;
    logic [DATA_W-1:0]  cnt_q [2];
    logic               armed;
    logic               active;

    // Evaluation gate: enabled, core out of reset, a match present,
    // and something configured to consume the result.
    assign armed  = (|brk_en) | (|route);
    assign active = dbg_en & ~cpu_in_reset & mp_any & armed;

    assign cnt_we[0] = reg_we && (reg_addr == ADDR_CNT0);
    assign cnt_we[1] = reg_we && (reg_addr == ADDR_CNT1);

    wpc_regs #(.N_MP(N_MP)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .chain_we    (reg_we && (reg_addr == ADDR_CHAIN)),
        .cfg_we      (reg_we && (reg_addr == ADDR_CTRL)),
        .chain_wdata (reg_wdata[CHAIN_W-1:0]),
        .cfg_wdata   (reg_wdata[CFG_W-1:0]),
        .new_hits    (new_hits),
        .chain_q     (chain_q),
        .cnt_en      (cnt_en),
        .route       (route),
        .brk_en      (brk_en),
        .status      (status)
    );

    wpc_chain #(.N_MP(N_MP)) i_chain (
        .mp_vec  (mp_vec),
        .chain_q (chain_q),
        .cnt_hit (cnt_hit),
        .wp_lo   (wp_lo),
        .wp_hi   (wp_hi)
    );

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        logic [N_MP-1:0] sel;
        assign sel = (g == 0) ? ~route : route;

        wpc_counter #(.N_MP(N_MP), .CNT_W(CNT_W)) i_counter (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cnt_we[g]),
            .wr_data (reg_wdata),
            .step_en (active & cnt_en[g]),
            .routed  (wp_lo & sel),
            .reg_q   (cnt_q[g]),
            .hit     (cnt_hit[g])
        );
    end

    assign new_hits = active ? ({wp_hi, wp_lo} & brk_en) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_req <= 1'b0;
        end else begin
            brk_req <= |new_hits;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CHAIN: reg_rdata = DATA_W'(chain_q);
            ADDR_CTRL:  reg_rdata = DATA_W'({status, brk_en, route, cnt_en});
            ADDR_CNT0:  reg_rdata = cnt_q[0];
            default:    reg_rdata = cnt_q[1];
        endcase
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!dbg_en || cpu_in_reset || !mp_any) |=> !brk_req); // R8

    AST_REQ_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (status != '0)); // R7

    AST_NO_ARM_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (brk_en == '0) |=> !brk_req); // R7

endmodule

// File: tb/test_wp_chain_brk.sv
`timescale 1ns/1ps
module test_wp_chain_brk;

    logic        clk = 1'b0;
    logic        rst;
    logic        dbg_en;
    logic        cpu_in_reset;
    logic [7:0]  mp_vec;
    logic        mp_any;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        brk_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wp_chain_brk i_wp_chain_brk (
        .clk(clk), .rst(rst), .dbg_en(dbg_en), .cpu_in_reset(cpu_in_reset),
        .mp_vec(mp_vec), .mp_any(mp_any), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_req(brk_req)
    );

    function automatic logic [31:0] cw(logic [1:0] en, logic [7:0] rt, logic [9:0] brk);
        return {12'd0, brk, rt, en};
    endfunction

    function automatic logic [31:0] cm(int idx, logic [1:0] mode);
        return 32'(mode) << (2 * idx);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev(logic [7:0] v);
        @(negedge clk);
        mp_vec = v; mp_any = 1'b1;
        @(negedge clk);
        mp_any = 1'b0; mp_vec = 8'h00;
    endtask

    task automatic ev_with_write(logic [7:0] v, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        mp_vec = v; mp_any = 1'b1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        mp_any = 1'b0; mp_vec = 8'h00; reg_we = 1'b0;
    endtask

    task automatic status_is(string tag, logic [9:0] exp);
        logic [31:0] d;
        rd(2'd1, d);
        check(tag, 32'(d[29:20]), 32'(exp));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R11 register zero after reset", d, 32'h0);
        end
        check("R11 brk_req low after reset", 32'(brk_req), 32'h0);
    endtask

    task automatic t_chain_modes();
        wr(2'd0, 32'h0);
        wr(2'd1, cw(2'b00, 8'h00, 10'h002));
        ev(8'h02);
        status_is("R1 mode 00 passes source", 10'h002);
        check("R1 brk_req after hit", 32'(brk_req), 32'h1);
        wr(2'd0, cm(1, 2'b01));
        wr(2'd1, cw(2'b00, 8'h00, 10'h002));
        ev(8'h02);
        status_is("R1 AND with false predecessor", 10'h000);
        ev(8'h03);
        status_is("R1 AND with true predecessor", 10'h002);
        wr(2'd0, cm(1, 2'b10));
        wr(2'd1, cw(2'b00, 8'h00, 10'h002));
        ev(8'h01);
        status_is("R1 OR from predecessor", 10'h002);
        wr(2'd0, cm(1, 2'b11));
        wr(2'd1, cw(2'b00, 8'h00, 10'h002));
        ev(8'h03);
        status_is("R1 reserved mode false", 10'h000);
        check("R1 no brk_req on reserved", 32'(brk_req), 32'h0);
    endtask

    task automatic t_serial();
        wr(2'd0, cm(1, 2'b10) | cm(2, 2'b10) | cm(3, 2'b10));
        wr(2'd1, cw(2'b00, 8'h00, 10'h008));
        ev(8'h01);
        status_is("R2 OR chain carries wp0 to wp3", 10'h008);
        wr(2'd0, cm(1, 2'b01) | cm(2, 2'b01) | cm(3, 2'b01));
        wr(2'd1, cw(2'b00, 8'h00, 10'h008));
        ev(8'h0E);
        status_is("R2 AND chain broken at wp0", 10'h000);
        ev(8'h0F);
        status_is("R2 AND chain complete", 10'h008);
    endtask

    task automatic t_wp0();
        wr(2'd0, cm(0, 2'b01));
        wr(2'd1, cw(2'b00, 8'h00, 10'h001));
        ev(8'h01);
        status_is("R3 wp0 AND mode false", 10'h000);
        wr(2'd0, cm(0, 2'b10));
        wr(2'd1, cw(2'b00, 8'h00, 10'h001));
        ev(8'h01);
        status_is("R3 wp0 OR mode false", 10'h000);
    endtask

    task automatic t_counters();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF_0000);
        wr(2'd3, 32'hFFFF_0000);
        wr(2'd1, cw(2'b11, 8'hF0, 10'h000));
        ev(8'h13);
        rd(2'd2, d); check("R4 counter0 counts wp0 wp1", d, 32'hFFFF_0002);
        rd(2'd3, d); check("R4 counter1 counts wp4", d, 32'hFFFF_0001);
        wr(2'd1, cw(2'b01, 8'hF0, 10'h000));
        ev(8'hF1);
        rd(2'd2, d); check("R4 counter0 still enabled", d, 32'hFFFF_0003);
        rd(2'd3, d); check("R4 disabled counter1 holds", d, 32'hFFFF_0001);
        wr(2'd2, 32'h1234_FFFF);
        ev(8'h03);
        rd(2'd2, d); check("R4 count wraps", d, 32'h1234_0001);
        wr(2'd1, cw(2'b11, 8'h00, 10'h000));
        ev(8'hFF);
        rd(2'd2, d); check("R8 no arm and no route skips counting", d, 32'h1234_0001);
    endtask

    task automatic t_count_match();
        wr(2'd0, 32'h0);
        wr(2'd1, cw(2'b01, 8'h00, 10'h300));
        wr(2'd2, {16'd3, 16'd1});
        wr(2'd3, {16'd5, 16'd0});
        ev(8'h01);
        status_is("R5 counter below match", 10'h000);
        ev(8'h01);
        status_is("R5 post-update count equals match", 10'h100);
        wr(2'd0, cm(8, 2'b01));
        wr(2'd1, cw(2'b01, 8'h00, 10'h300));
        wr(2'd2, {16'd4, 16'd3});
        ev(8'h01);
        status_is("R5 wp8 AND with false wp7", 10'h000);
        wr(2'd1, cw(2'b01, 8'h00, 10'h300));
        wr(2'd2, {16'd6, 16'd4});
        ev(8'h81);
        status_is("R5 wp8 AND with true wp7", 10'h100);
        wr(2'd0, cm(9, 2'b10));
        wr(2'd1, cw(2'b01, 8'h00, 10'h300));
        wr(2'd2, {16'd7, 16'd6});
        ev(8'h01);
        status_is("R5 wp9 OR from wp8", 10'h300);
    endtask

    task automatic t_no_match();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h00FF_0010);
        wr(2'd1, cw(2'b11, 8'h00, 10'h3FF));
        @(negedge clk);
        mp_vec = 8'hFF; mp_any = 1'b0;
        @(negedge clk);
        mp_vec = 8'h00;
        status_is("R6 no status without any-match", 10'h000);
        check("R6 no brk_req without any-match", 32'(brk_req), 32'h0);
        rd(2'd2, d); check("R6 counter unchanged", d, 32'h00FF_0010);
    endtask

    task automatic t_gates();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        wr(2'd1, cw(2'b00, 8'h00, 10'h0FF));
        dbg_en = 1'b0;
        ev(8'hFF);
        status_is("R8 disabled gives no status", 10'h000);
        check("R8 disabled gives no brk_req", 32'(brk_req), 32'h0);
        dbg_en = 1'b1; cpu_in_reset = 1'b1;
        ev(8'hFF);
        status_is("R8 in-reset gives no status", 10'h000);
        cpu_in_reset = 1'b0;
        ev(8'h01);
        rd(2'd1, d);
        check("R8 enabled again evaluates", 32'(d[20]), 32'h1);
    endtask

    task automatic t_sticky();
        wr(2'd0, 32'h0);
        wr(2'd1, cw(2'b00, 8'h00, 10'h001));
        ev(8'h01);
        status_is("R7 armed hit sets status", 10'h001);
        check("R7 brk_req pulses", 32'(brk_req), 32'h1);
        @(negedge clk);
        check("R7 brk_req drops after idle cycle", 32'(brk_req), 32'h0);
        ev(8'h04);
        status_is("R9 status sticky across unarmed hit", 10'h001);
        check("R7 unarmed hit gives no brk_req", 32'(brk_req), 32'h0);
        wr(2'd1, cw(2'b00, 8'h00, 10'h001));
        status_is("R9 control write clears status", 10'h000);
        ev_with_write(8'h01, 2'd1, cw(2'b00, 8'h00, 10'h001));
        status_is("R9 same-cycle hit beats clear", 10'h001);
        check("R9 brk_req on same-cycle hit", 32'(brk_req), 32'h1);
    endtask

    task automatic t_cnt_write();
        logic [31:0] d;
        wr(2'd0, 32'h0);
        wr(2'd1, cw(2'b01, 8'h00, 10'h002));
        wr(2'd2, 32'hABCD_0005);
        rd(2'd2, d); check("R10 counter fields read back", d, 32'hABCD_0005);
        ev_with_write(8'h03, 2'd2, 32'h1111_0042);
        rd(2'd2, d); check("R10 write beats increment", d, 32'h1111_0042);
        ev(8'h01);
        rd(2'd2, d); check("R10 counts from written value", d, 32'h1111_0043);
    endtask

    initial begin
        rst = 1'b1; dbg_en = 1'b1; cpu_in_reset = 1'b0;
        mp_vec = 8'h00; mp_any = 1'b0;
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_chain_modes();
        t_serial();
        t_wp0();
        t_counters();
        t_count_match();
        t_no_match();
        t_gates();
        t_sticky();
        t_cnt_write();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule